// File: doc/BRIEF.md
# Memory Read Target for a 4-bit Multiplexed Host Bus

This block is the target side of a memory read transaction on a narrow host bus. The bus carries address, control and data four bits at a time, and a low-active frame strobe marks where each cycle begins. The block waits for a start nibble and a memory-read cycle code. It then shifts in a 32-bit address over eight clocks. It keeps only the low 24 bits, and it claims the cycle only when the address bits that select a device equal the bitwise inverse of the four strap inputs.

Once it has claimed a cycle, the block sends a one-cycle read request to a back end. The request carries the 24-bit address and a flag that picks the storage array or the register space. After the host's two-clock turn-around, the block holds the bus with wait codes until the back end returns a byte. It then sends the ready code and the byte, low nibble first. Last, it drives an all-ones turn-around nibble and releases the bus. A low frame strobe at any point cancels the cycle in progress. The strap inputs must stay static while a cycle is in flight.

Top module: `lpc_mem_rd_target`

## Requirements
- R1: After synchronous reset the block is idle: `bus_oe` is 0 and `rd_req` is 0.
- R2: A cycle begins when the frame strobe is low with a bus nibble of 0000b. The cycle is a read only when the nibble that follows has bits [3:1] equal to 010b, with bit 0 not checked. Any other code leaves the bus undriven and raises no request for the rest of that cycle.
- R3: The eight nibbles after the cycle code form the address, most significant nibble first. `rd_addr` equals address bits 23..0, so bits 31..24 have no effect.
- R4: `rd_array` equals address bit 23: 1 selects the storage array and 0 selects register space.
- R5: The cycle is claimed only if address bits 22..19 equal `~sel_strap`. Otherwise the block never drives the bus and raises no request in that cycle.
- R6: A claimed cycle raises `rd_req` for exactly one clock, in the clock after the last address nibble. The block does not drive the bus during the two host turn-around clocks that follow.
- R7: From the third clock after the last address nibble, the block drives 0101b each clock until `rd_valid` has been seen. It then drives 0000b for one clock. A byte returned during the turn-around clocks yields no wait code at all.
- R8: After the 0000b code, the block drives the captured byte over two clocks: bits 3..0 first, then bits 7..4.
- R9: After the data, the block drives 1111b for one clock and then releases the bus (`bus_oe` = 0).
- R10: A low frame strobe during any clock of a cycle aborts it. From the next clock on, `bus_oe` is 0 and the block waits for a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_n | input | 1 | Frame strobe, low marks a cycle start or abort |
| bus_in | input | 4 | Nibble sampled from the bus |
| bus_out | output | 4 | Nibble driven onto the bus |
| bus_oe | output | 1 | Output enable for `bus_out` |
| sel_strap | input | 4 | Static device-select straps, compared inverted |
| rd_req | output | 1 | One-clock read request to the back end |
| rd_addr | output | 24 | Decoded read address |
| rd_array | output | 1 | 1 = storage array, 0 = register space |
| rd_valid | input | 1 | Back end returns the byte |
| rd_data | input | 8 | Byte from the back end |

## Verification
The bench targets back-end latencies on both sides of the turn-around boundary. A design that miscounted there would emit a spurious wait code when the byte came back early, or skip a needed one when it came back late. It also sends odd cycle codes, straps that do not match, and nonzero top address bits. A target that decoded too many address bits, or compared the straps uninverted, would claim cycles that belong to other devices. Aborts are placed in the address, wait, data and final turn-around phases, so a design that kept driving after a cancelled cycle would show up as bus contention. A design that swapped the nibble order would show up as byte-swapped data.

// File: rtl/lpc_rd_pkg.sv
package lpc_rd_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_TYPE, ST_ADDR, ST_HTA, ST_WAIT,
    ST_RDY, ST_DLO, ST_DHI, ST_TTA, ST_DROP
  } rd_state_e;

  localparam logic [NIB_W-1:0] NIB_START = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_WAIT  = 4'b0101;
  localparam logic [NIB_W-1:0] NIB_READY = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_ONES  = 4'b1111;
  localparam logic [2:0]       TYPE_MRD  = 3'b010;
endpackage

// File: rtl/lpc_addr_shift.sv
module lpc_addr_shift #(
  parameter int NIB_W     = 4,
  parameter int ADDR_NIBS = 8,
  parameter int DEC_W     = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             shift,
  input  logic [NIB_W-1:0] nib,
  output logic [DEC_W-1:0] addr_q,
  output logic [DEC_W-1:0] addr_nx,
  output logic             last
);
  localparam int CW = $clog2(ADDR_NIBS + 1);
  logic [CW-1:0] cnt_q;

  // upper address nibbles fall off the top of the shift register
  assign addr_nx = {addr_q[DEC_W-NIB_W-1:0], nib};
  assign last    = shift && (cnt_q == CW'(ADDR_NIBS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (shift) addr_q <= addr_nx;
      if (clr)        cnt_q <= '0;
      else if (shift) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lpc_rd_fsm.sv
module lpc_rd_fsm
  import lpc_rd_pkg::*;
#(
  parameter int DEC_W   = 24,
  parameter int SEL_W   = 4,
  parameter int SEL_LSB = 19,
  parameter int HT_CLKS = 2,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_n,
  input  logic [NIB_W-1:0]  bus_in,
  input  logic [SEL_W-1:0]  sel_strap,
  input  logic              addr_last,
  input  logic [DEC_W-1:0]  addr_nx,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output rd_state_e         state_q,
  output rd_state_e         state_d,
  output logic [DATA_W-1:0] dat_d,
  output logic              rd_req,
  output logic              shift_en,
  output logic              addr_clr
);
  localparam int HCW = $clog2(HT_CLKS + 1);

  logic [HCW-1:0]    ht_cnt;
  logic              ht_done, sel_ok, pend_q, have_q, have_d, take;
  logic [DATA_W-1:0] dat_q;

  assign shift_en = strobe_n && (state_q == ST_ADDR);
  assign addr_clr = (state_q != ST_ADDR) || !strobe_n;
  assign sel_ok   = (addr_nx[SEL_LSB +: SEL_W] == ~sel_strap);
  assign ht_done  = (ht_cnt == HCW'(HT_CLKS - 1));
  assign take     = pend_q && rd_valid;
  assign have_d   = have_q || take;
  assign dat_d    = take ? rd_data : dat_q;

  always_comb begin
    state_d = state_q;
    if (!strobe_n) begin
      state_d = (bus_in == NIB_START) ? ST_TYPE : ST_IDLE;
    end else begin
      unique case (state_q)
        ST_TYPE: state_d = (bus_in[3:1] == TYPE_MRD) ? ST_ADDR : ST_DROP;
        ST_ADDR: if (addr_last) state_d = sel_ok ? ST_HTA : ST_DROP;
        ST_HTA:  if (ht_done) state_d = have_d ? ST_RDY : ST_WAIT;
        ST_WAIT: if (have_d) state_d = ST_RDY;
        ST_RDY:  state_d = ST_DLO;
        ST_DLO:  state_d = ST_DHI;
        ST_DHI:  state_d = ST_TTA;
        ST_TTA:  state_d = ST_IDLE;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ht_cnt  <= '0;
      rd_req  <= 1'b0;
      pend_q  <= 1'b0;
      have_q  <= 1'b0;
      dat_q   <= '0;
    end else begin
      state_q <= state_d;
      ht_cnt  <= (state_q == ST_HTA && strobe_n) ? ht_cnt + 1'b1 : '0;
      rd_req  <= addr_last && sel_ok;
      if (!strobe_n)              pend_q <= 1'b0;
      else if (addr_last && sel_ok) pend_q <= 1'b1;
      else if (rd_valid)          pend_q <= 1'b0;
      have_q  <= (!strobe_n || state_d == ST_IDLE) ? 1'b0 : have_d;
      dat_q   <= dat_d;
    end
  end

  assert_req_once_R6: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
  assert_tta_to_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TTA && strobe_n) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/lpc_bus_drive.sv
module lpc_bus_drive
  import lpc_rd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  rd_state_e         state_d,
  input  logic [DATA_W-1:0] dat_d,
  output logic [NIB_W-1:0]  bus_out,
  output logic              bus_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out <= NIB_ONES;
      bus_oe  <= 1'b0;
    end else begin
      bus_oe <= 1'b1;
      unique case (state_d)
        ST_WAIT: bus_out <= NIB_WAIT;
        ST_RDY:  bus_out <= NIB_READY;
        ST_DLO:  bus_out <= dat_d[NIB_W-1:0];
        ST_DHI:  bus_out <= dat_d[2*NIB_W-1:NIB_W];
        ST_TTA:  bus_out <= NIB_ONES;
        default: begin
          bus_out <= NIB_ONES;
          bus_oe  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/lpc_mem_rd_target.sv
module lpc_mem_rd_target
  import lpc_rd_pkg::*;
#(
  parameter int ADDR_NIBS = 8,
  parameter int DEC_W     = 24,
  parameter int SEL_W     = 4,
  parameter int SEL_LSB   = 19,
  parameter int SPACE_BIT = 23,
  parameter int HT_CLKS   = 2,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_n,
  input  logic [3:0]        bus_in,
  output logic [3:0]        bus_out,
  output logic              bus_oe,
  input  logic [SEL_W-1:0]  sel_strap,
  output logic              rd_req,
  output logic [DEC_W-1:0]  rd_addr,
  output logic              rd_array,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data
);
  rd_state_e         state_q, state_d;
  logic [DATA_W-1:0] dat_d;
  logic [DEC_W-1:0]  addr_nx;
  logic              addr_last, shift_en, addr_clr;

  lpc_addr_shift #(.NIB_W(NIB_W), .ADDR_NIBS(ADDR_NIBS), .DEC_W(DEC_W)) u_addr (
    .clk(clk), .rst(rst), .clr(addr_clr), .shift(shift_en), .nib(bus_in),
    .addr_q(rd_addr), .addr_nx(addr_nx), .last(addr_last)
  );

  lpc_rd_fsm #(.DEC_W(DEC_W), .SEL_W(SEL_W), .SEL_LSB(SEL_LSB),
               .HT_CLKS(HT_CLKS), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .strobe_n(strobe_n), .bus_in(bus_in),
    .sel_strap(sel_strap), .addr_last(addr_last), .addr_nx(addr_nx),
    .rd_valid(rd_valid), .rd_data(rd_data), .state_q(state_q),
    .state_d(state_d), .dat_d(dat_d), .rd_req(rd_req),
    .shift_en(shift_en), .addr_clr(addr_clr)
  );

  lpc_bus_drive #(.DATA_W(DATA_W)) u_drv (
    .clk(clk), .rst(rst), .state_d(state_d), .dat_d(dat_d),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  assign rd_array = rd_addr[SPACE_BIT];

  assert_abort_release_R10: assert property (@(posedge clk) disable iff (rst)
    !strobe_n |=> !bus_oe);
  assert_req_sel_R5: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (rd_addr[SEL_LSB +: SEL_W] == ~sel_strap));
  assert_ready_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && bus_out == NIB_READY && strobe_n) |=> bus_oe);
endmodule

// File: tb/test_lpc_mem_rd_target.sv
module test_lpc_mem_rd_target;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe_n = 1'b1;
  logic [3:0]  bus_in = 4'hF;
  logic [3:0]  bus_out;
  logic        bus_oe;
  logic [3:0]  sel_strap = 4'h0;
  logic        rd_req;
  logic [23:0] rd_addr;
  logic        rd_array;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data = 8'h00;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lpc_mem_rd_target i_lpc_mem_rd_target (
    .clk(clk), .rst(rst), .strobe_n(strobe_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .sel_strap(sel_strap),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_array(rd_array),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int wait_clocks(input int lat);
    return (lat > 2) ? lat - 2 : 0;
  endfunction

  // one whole read cycle; abort_at < 0 means no abort
  task automatic run_rd(input logic [31:0] a, input logic [3:0] typ,
                        input logic [3:0] strap, input int lat,
                        input int abort_at, input logic [7:0] dat);
    bit    type_ok = (typ[3:1] == 3'b010);
    bit    id_ok   = (a[22:19] == ~strap);
    bit    hit     = type_ok && id_ok;
    int    w       = wait_clocks(lat);
    int    last_c  = 17 + w;
    bit    req_exp = hit && !(abort_at >= 0 && abort_at < 10);
    int    reqs    = 0;
    string miss    = type_ok ? "R5" : "R2";
    sel_strap = strap;
    for (int c = 0; c <= last_c; c++) begin
      @(negedge clk);
      if (c >= 1) begin
        bit          e_oe = 1'b0;
        logic [3:0]  e_v  = 4'hF;
        string       tag;
        if (abort_at >= 0 && c > abort_at) tag = "R10";
        else if (!hit)                     tag = miss;
        else if (c < 12)                   tag = "R6";
        else if (c < 12 + w)  begin tag = "R7"; e_oe = 1; e_v = 4'b0101; end
        else if (c == 12 + w) begin tag = "R7"; e_oe = 1; e_v = 4'b0000; end
        else if (c == 13 + w) begin tag = "R8"; e_oe = 1; e_v = dat[3:0]; end
        else if (c == 14 + w) begin tag = "R8"; e_oe = 1; e_v = dat[7:4]; end
        else if (c == 15 + w) begin tag = "R9"; e_oe = 1; e_v = 4'hF; end
        else                              tag = "R9";
        chk(bus_oe == e_oe, tag, "bus_oe", int'(bus_oe), int'(e_oe));
        if (e_oe) chk(bus_out == e_v, tag, "bus_out", int'(bus_out), int'(e_v));
        if (rd_req) reqs++;
        if (c == 10 && req_exp) begin
          chk(rd_req == 1'b1, "R6", "rd_req", int'(rd_req), 1);
          chk(rd_addr == a[23:0], "R3", "rd_addr", int'(rd_addr), int'(a[23:0]));
          chk(rd_array == a[23], "R4", "rd_array", int'(rd_array), int'(a[23]));
        end
      end
      strobe_n = !(c == 0 || c == abort_at);
      if (c == 0)             bus_in = 4'h0;
      else if (c == abort_at) bus_in = 4'h9;
      else if (c == 1)        bus_in = typ;
      else if (c <= 9)        bus_in = 4'((a >> (4 * (9 - c))) & 32'hF);
      else                    bus_in = 4'hF;
      rd_valid = hit && (c == 9 + lat) && !(abort_at >= 0 && c >= abort_at);
      rd_data  = rd_valid ? dat : ~dat;
    end
    chk(reqs == int'(req_exp), req_exp ? "R6" : (hit ? "R10" : miss),
        "request count", reqs, int'(req_exp));
    @(negedge clk);
    strobe_n = 1'b1;
    bus_in   = 4'hF;
    rd_valid = 1'b0;
    chk(bus_oe == 1'b0, "R9", "idle after cycle", int'(bus_oe), 0);
  endtask

  function automatic logic [31:0] addr_for(input logic [31:0] r,
                                           input logic [3:0] strap,
                                           input bit match);
    logic [31:0] v = r;
    v[22:19] = match ? ~strap : (~strap ^ 4'b0110);
    return v;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5A17C3E1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    chk(bus_oe == 1'b0, "R1", "bus_oe after reset", int'(bus_oe), 0);
    chk(rd_req == 1'b0, "R1", "rd_req after reset", int'(rd_req), 0);

    // directed corners
    run_rd(addr_for(32'hA5C12345, 4'h3, 1), 4'b0100, 4'h3, 1, -1, 8'h3C); // R3 R4 array
    run_rd(addr_for(32'h7F412ABC, 4'hA, 1), 4'b0101, 4'hA, 2, -1, 8'hE1); // R2 bit0, R4 regs
    run_rd(addr_for(32'h00801234, 4'h5, 1), 4'b0100, 4'h5, 3, -1, 8'h07); // R7 one wait
    run_rd(addr_for(32'hFF9FFFFF, 4'h0, 1), 4'b0100, 4'h0, 9, -1, 8'hB2); // R7 long wait
    run_rd(addr_for(32'h12345678, 4'h6, 0), 4'b0100, 4'h6, 2, -1, 8'h55); // R5 miss
    run_rd(addr_for(32'h12345678, 4'h6, 1), 4'b0110, 4'h6, 2, -1, 8'h55); // R2 bad code
    run_rd(addr_for(32'h89ABCDEF, 4'h9, 1), 4'b0100, 4'h9, 2, 5, 8'h44);  // R10 in address
    run_rd(addr_for(32'h89ABCDEF, 4'h9, 1), 4'b0100, 4'h9, 6, 13, 8'h44); // R10 in wait
    run_rd(addr_for(32'h89ABCDEF, 4'h9, 1), 4'b0100, 4'h9, 1, 13, 8'h44); // R10 in data
    run_rd(addr_for(32'h89ABCDEF, 4'h9, 1), 4'b0100, 4'h9, 1, 15, 8'h44); // R10 in final turn

    // constrained random
    for (int t = 0; t < 60; t++) begin
      logic [3:0]  strap = 4'($urandom);
      logic [3:0]  typ   = ($urandom % 4 != 0) ? {3'b010, 1'($urandom)} : 4'($urandom);
      bit          m     = ($urandom % 4 != 0);
      int          lat   = 1 + int'($urandom % 7);
      int          ab    = ($urandom % 5 == 0) ? 2 + int'($urandom % (14 + wait_clocks(lat))) : -1;
      run_rd(addr_for($urandom, strap, m), typ, strap, lat, ab, 8'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule